// File: doc/BRIEF.md
# Center-Aligned Dual-Slope PWM Timer

This block is a 16-bit up/down timer that produces symmetric, center-aligned pulse-width modulation on two or three compare channels. The counter climbs from zero to a turn-around value, holds it for one timer tick and then descends back to zero. Each channel compares the running count against its own threshold. A match drives the channel pin one way on the rising slope and the other way on the falling slope, so every pulse is centred on the turn-around point.

Software chooses the turn-around value through a mode code. It can pick one of three fixed resolutions, a separate period register, or the threshold of channel A. Thresholds are written into shadow buffers. They move into the active copies only at the turn-around tick, so a period is never cut short or glitched. A timer-clock enable paces the counting. Three kinds of sticky event flag (bottom reached, channel match, period reached) each have their own clear input.

Top module: `pwm_ds_timer`

## Requirements
- R1: The mode register is at write address 0, in data bits [3:0]. Code 1 sets the turn-around value (TOP) to 0x00FF, code 2 to 0x01FF, code 3 to 0x03FF. Code 10 uses the period register, written at address 1. Code 11 uses channel A's active threshold. Any other code stops the counter at its present value, and no flag is set.
- R2: On each counting tick the count moves by exactly one. From zero it goes to 1 and counts up. While counting up it reaches TOP, stays there for exactly one tick, and then counts down toward zero.
- R3: The count, the direction, the pins and the flags change only in cycles where `tick_en` is high and the mode is a counting mode.
- R4: A tick in which the count is zero sets `ovf_flag` in the next cycle.
- R5: Channel thresholds are written to buffers at addresses 2, 3 and 4 (channels A, B, C). In a counting mode a buffer is copied to the active threshold only on the tick in which the count equals TOP. In a stopped mode the active threshold follows the buffer one cycle later.
- R6: On the tick at TOP, mode 10 sets `prd_flag` and mode 11 sets `cmp_flag[0]`. These flags rise in the same cycle as the buffered thresholds take effect.
- R7: A tick in which the count equals a channel's active threshold sets that channel's `cmp_flag` in the next cycle.
- R8: A channel whose threshold lies above TOP never matches and never sets its flag.
- R9: In modes 1 to 3, threshold bits above the selected resolution are forced to zero when the threshold is written. For example, 0x1234 written in mode 1 becomes 0x0034.
- R10: The output modes sit at address 5, with two bits per channel starting at bit 0 (channel A in bits [1:0]). Mode 2 is non-inverted: a match clears the pin while counting up and sets it while counting down. Mode 3 does the opposite. Modes 0 and 1 hold the pin low.
- R11: Every flag stays set until its clear input is high. If a set and a clear come in the same cycle, the set wins.
- R12: After reset the count is zero and counting up, and all flags, pins, buffers and registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| ovf_clr | input | 1 | Clears the bottom flag |
| prd_clr | input | 1 | Clears the period flag |
| cmp_clr | input | NUM_CH | Clears the channel match flags |
| count | output | 16 | Present counter value |
| pwm_out | output | NUM_CH | PWM pins |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| prd_flag | output | 1 | Sticky period-reached flag (mode 10) |
| cmp_flag | output | NUM_CH | Sticky channel match flags |

## Verification
The step-by-one and turn-around properties assume that TOP is never set below the present count while the counter is rising. They also assume TOP is at least 3. The stimulus therefore changes the mode and the period only while the counter is stopped, or to values larger than the count. It moves channel A's threshold in mode 11 only through the buffer, which takes effect at the turn-around tick. The flag properties assume clear pulses are only one cycle wide, and every clear in the bench is a one-cycle strobe.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

   localparam int MODE_W = 4;
   localparam int ADDR_W = 3;
   localparam int OM_W   = 2;

   typedef logic [MODE_W-1:0] mode_t;
   typedef logic [OM_W-1:0]   omode_t;

   localparam mode_t MODE_FIX8  = 4'd1;
   localparam mode_t MODE_FIX9  = 4'd2;
   localparam mode_t MODE_FIX10 = 4'd3;
   localparam mode_t MODE_PRD   = 4'd10;
   localparam mode_t MODE_CMPA  = 4'd11;

   localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_PRD   = 3'd1;
   localparam int                ADDR_CMP0  = 2;
   localparam logic [ADDR_W-1:0] ADDR_OMODE = 3'd5;

   localparam int MIN_CNT_W = 10;
   localparam int MAX_CNT_W = 16;

   function automatic logic mode_is_fixed(mode_t m);
      return (m == MODE_FIX8) || (m == MODE_FIX9) || (m == MODE_FIX10);
   endfunction

   function automatic logic mode_is_running(mode_t m);
      return mode_is_fixed(m) || (m == MODE_PRD) || (m == MODE_CMPA);
   endfunction

   function automatic logic [15:0] fixed_top(mode_t m);
      case (m)
         MODE_FIX8:  return 16'h00FF;
         MODE_FIX9:  return 16'h01FF;
         MODE_FIX10: return 16'h03FF;
         default:    return 16'hFFFF;
      endcase
   endfunction

endpackage

// File: rtl/pwm_ds_flag.sv
module pwm_ds_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end
endmodule

// File: rtl/pwm_ds_regs.sv
module pwm_ds_regs
   import pwm_ds_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CNT_W-1:0]         wr_data,
   output mode_t                    mode_q,
   output logic [CNT_W-1:0]         prd_q,
   output logic [NUM_CH*CNT_W-1:0]  cmp_buf_q,
   output logic [NUM_CH*OM_W-1:0]   omode_q
);
   localparam int OMODE_BITS = NUM_CH * OM_W;

   logic [CNT_W-1:0] wr_mask;

   always_comb begin
      if (mode_is_fixed(mode_q)) wr_mask = CNT_W'(fixed_top(mode_q));
      else                       wr_mask = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         prd_q   <= '0;
         omode_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_MODE)  mode_q  <= wr_data[MODE_W-1:0];
         if (wr_addr == ADDR_PRD)   prd_q   <= wr_data;
         if (wr_addr == ADDR_OMODE) omode_q <= wr_data[OMODE_BITS-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_buf
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_CMP0 + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_buf_q[i*CNT_W +: CNT_W] <= '0;
         else if (wr_en && wr_addr == MY_ADDR)
            cmp_buf_q[i*CNT_W +: CNT_W] <= wr_data & wr_mask;
      end
   end
endmodule

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             up_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero;
   logic turn_down;

   assign at_zero   = (cnt_q == '0);
   assign turn_down = up_q && (cnt_q >= top_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         if (at_zero) begin
            cnt_q <= ONE;
            up_q  <= 1'b1;
         end else if (turn_down) begin
            cnt_q <= cnt_q - ONE;
            up_q  <= 1'b0;
         end else if (up_q) begin
            cnt_q <= cnt_q + ONE;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/pwm_ds_channel.sv
module pwm_ds_channel
   import pwm_ds_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   input  logic [CNT_W-1:0] cnt,
   input  logic             load_now,
   input  logic [CNT_W-1:0] buf_val,
   input  omode_t           omode,
   input  logic             extra_set,
   input  logic             clr_req,
   output logic [CNT_W-1:0] act_q,
   output logic             pin,
   output logic             flag
);
   logic match;
   logic pin_q;

   assign match = step && (cnt == act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_q <= '0;
      else if (load_now) act_q <= buf_val;
   end

   // omode[0] selects polarity: 0 clears on the rising slope, 1 sets on it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pin_q <= 1'b0;
      else if (match) pin_q <= up ? omode[0] : ~omode[0];
   end

   assign pin = omode[1] & pin_q;

   pwm_ds_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (match | extra_set),
      .clr_req (clr_req),
      .flag_q  (flag)
   );
endmodule

// File: rtl/pwm_ds_timer.sv
module pwm_ds_timer
   import pwm_ds_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              ovf_clr,
   input  logic              prd_clr,
   input  logic [NUM_CH-1:0] cmp_clr,
   output logic [CNT_W-1:0]  count,
   output logic [NUM_CH-1:0] pwm_out,
   output logic              ovf_flag,
   output logic              prd_flag,
   output logic [NUM_CH-1:0] cmp_flag
);
   if (NUM_CH < 2 || NUM_CH > 3) begin : g_bad_ch
      $error("pwm_ds_timer: NUM_CH must be 2 or 3");
   end
   if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_w
      $error("pwm_ds_timer: CNT_W must lie in 10..16");
   end

   mode_t                   mode_q;
   logic [CNT_W-1:0]        prd_q;
   logic [NUM_CH*CNT_W-1:0] cmp_buf;
   logic [NUM_CH*OM_W-1:0]  out_mode;
   logic [NUM_CH*CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0]        top_val;
   logic                    running;
   logic                    step;
   logic                    up_dir;
   logic                    top_evt;
   logic                    load_now;

   pwm_ds_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .mode_q    (mode_q),
      .prd_q     (prd_q),
      .cmp_buf_q (cmp_buf),
      .omode_q   (out_mode)
   );

   assign running = mode_is_running(mode_q);
   assign step    = tick_en && running;

   always_comb begin
      if (mode_is_fixed(mode_q))  top_val = CNT_W'(fixed_top(mode_q));
      else if (mode_q == MODE_PRD) top_val = prd_q;
      else                         top_val = cmp_act[CNT_W-1:0];
   end

   pwm_ds_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .top_val (top_val),
      .cnt_q   (count),
      .up_q    (up_dir)
   );

   assign top_evt  = step && (count == top_val);
   assign load_now = !running || top_evt;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic extra;
      if (i == 0) begin : g_a
         assign extra = top_evt && (mode_q == MODE_CMPA);
      end else begin : g_o
         assign extra = 1'b0;
      end
      pwm_ds_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (step),
         .up        (up_dir),
         .cnt       (count),
         .load_now  (load_now),
         .buf_val   (cmp_buf[i*CNT_W +: CNT_W]),
         .omode     (out_mode[i*OM_W +: OM_W]),
         .extra_set (extra),
         .clr_req   (cmp_clr[i]),
         .act_q     (cmp_act[i*CNT_W +: CNT_W]),
         .pin       (pwm_out[i]),
         .flag      (cmp_flag[i])
      );
   end

   pwm_ds_flag u_ovf (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (step && (count == '0)),
      .clr_req (ovf_clr),
      .flag_q  (ovf_flag)
   );

   pwm_ds_flag u_prd (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (top_evt && (mode_q == MODE_PRD)),
      .clr_req (prd_clr),
      .flag_q  (prd_flag)
   );
endmodule

// File: rtl/pwm_ds_checker.sv
module pwm_ds_checker #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              running,
   input logic [CNT_W-1:0]  top_val,
   input logic [CNT_W-1:0]  count,
   input logic              ovf_flag,
   input logic              ovf_clr,
   input logic              prd_flag,
   input logic              prd_clr
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic stepping;
   assign stepping = tick_en && running;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      stepping |=> (count == $past(count) + ONE) || (count == $past(count) - ONE)); // R2
   AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && count == '0 |=> count == ONE); // R2
   AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && count == top_val && count != '0 |=> count == $past(count) - ONE); // R2
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !stepping |=> $stable(count)); // R3
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && count == '0 |=> ovf_flag); // R4
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag); // R11
   AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr && !(stepping && count == '0) |=> !ovf_flag); // R11
   AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      prd_flag && !prd_clr |=> prd_flag); // R11
endmodule

bind pwm_ds_timer pwm_ds_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .running  (running),
   .top_val  (top_val),
   .count    (count),
   .ovf_flag (ovf_flag),
   .ovf_clr  (ovf_clr),
   .prd_flag (prd_flag),
   .prd_clr  (prd_clr)
);

// File: tb/tb_pwm_ds_timer.sv
module tb_pwm_ds_timer;
   localparam int W  = 16;
   localparam int NC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          ovf_clr = 1'b0;
   logic          prd_clr = 1'b0;
   logic [NC-1:0] cmp_clr = '0;
   logic [W-1:0]  count;
   logic [NC-1:0] pwm_out;
   logic          ovf_flag;
   logic          prd_flag;
   logic [NC-1:0] cmp_flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit model_on = 1'b0;
   string cur_req = "R12";

   // reference state, built from the requirements
   logic [3:0]   m_mode;
   logic [W-1:0] m_prd, m_cnt;
   logic [W-1:0] m_buf [NC];
   logic [W-1:0] m_act [NC];
   logic [5:0]   m_om;
   logic         m_up, m_of, m_pf;
   logic [NC-1:0] m_pin, m_cf;

   always #10 clk = ~clk;

   pwm_ds_timer #(.CNT_W(W), .NUM_CH(NC)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ovf_clr(ovf_clr),
      .prd_clr(prd_clr), .cmp_clr(cmp_clr), .count(count),
      .pwm_out(pwm_out), .ovf_flag(ovf_flag), .prd_flag(prd_flag),
      .cmp_flag(cmp_flag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_running();
      return m_mode inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11};
   endfunction

   function automatic logic [W-1:0] m_top();
      case (m_mode)
         4'd1:  return 16'h00FF;
         4'd2:  return 16'h01FF;
         4'd3:  return 16'h03FF;
         4'd10: return m_prd;
         4'd11: return m_act[0];
         default: return '0;
      endcase
   endfunction

   task automatic model_reset();
      m_mode = '0; m_prd = '0; m_cnt = '0; m_om = '0;
      m_up = 1'b1; m_of = 1'b0; m_pf = 1'b0; m_pin = '0; m_cf = '0;
      for (int i = 0; i < NC; i++) begin m_buf[i] = '0; m_act[i] = '0; end
   endtask

   task automatic model_step();
      bit run_c, tk, at_top, at_bot;
      logic [W-1:0] top_c, mask;
      run_c  = m_running();
      top_c  = m_top();
      tk     = tick_en && run_c;
      at_top = tk && (m_cnt == top_c);
      at_bot = tk && (m_cnt == '0);
      for (int i = 0; i < NC; i++) begin
         bit hit, setf;
         hit = tk && (m_cnt == m_act[i]);
         if (hit) begin
            // output mode 2 (bit0=0): up-match clears, down-match sets; mode 3 reversed
            if (m_up) m_pin[i] = m_om[2*i];
            else      m_pin[i] = !m_om[2*i];
         end
         setf = hit || (i == 0 && at_top && m_mode == 4'd11);
         if (setf) m_cf[i] = 1'b1; else if (cmp_clr[i]) m_cf[i] = 1'b0;
      end
      if (at_bot) m_of = 1'b1; else if (ovf_clr) m_of = 1'b0;
      if (at_top && m_mode == 4'd10) m_pf = 1'b1; else if (prd_clr) m_pf = 1'b0;
      if (tk) begin
         if (m_cnt == '0) begin m_cnt = 1; m_up = 1'b1; end
         else if (m_up && m_cnt >= top_c) begin m_cnt = m_cnt - 1; m_up = 1'b0; end
         else if (m_up) m_cnt = m_cnt + 1;
         else m_cnt = m_cnt - 1;
      end
      for (int i = 0; i < NC; i++)
         if (!run_c || at_top) m_act[i] = m_buf[i];
      if (wr_en) begin
         mask = (m_mode inside {4'd1, 4'd2, 4'd3}) ? m_top() : 16'hFFFF;
         case (wr_addr)
            3'd0: m_mode = wr_data[3:0];
            3'd1: m_prd  = wr_data;
            3'd2: m_buf[0] = wr_data & mask;
            3'd3: m_buf[1] = wr_data & mask;
            3'd4: m_buf[2] = wr_data & mask;
            3'd5: m_om = wr_data[5:0];
            default: ;
         endcase
      end
   endtask

   task automatic compare_model();
      logic [NC-1:0] exp_pin;
      for (int i = 0; i < NC; i++) exp_pin[i] = m_om[2*i+1] & m_pin[i];
      chk(count == m_cnt, cur_req, "count", count, m_cnt);
      chk(pwm_out == exp_pin, cur_req, "pwm_out", pwm_out, exp_pin);
      chk({ovf_flag, prd_flag, cmp_flag} == {m_of, m_pf, m_cf}, cur_req, "flags",
          {ovf_flag, prd_flag, cmp_flag}, {m_of, m_pf, m_cf});
   endtask

   // one clock: inputs already driven, sample at the falling edge, release strobes
   task automatic cyc();
      @(posedge clk);
      if (model_on) model_step();
      @(negedge clk);
      if (model_on) compare_model();
      wr_en = 1'b0; ovf_clr = 1'b0; prd_clr = 1'b0; cmp_clr = '0;
   endtask

   task automatic wreg(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
   endtask

   task automatic clear_all();
      ovf_clr = 1'b1; prd_clr = 1'b1; cmp_clr = '1;
      cyc();
   endtask

   task automatic stop_and_home();
      wreg(3'd0, 16'd0);
      rst_n = 1'b0; model_reset(); @(negedge clk); rst_n = 1'b1; @(negedge clk);
   endtask

   task automatic t_reset();
      cur_req = "R12";
      chk(count == '0, "R12", "count after reset", count, 0);
      chk(pwm_out == '0, "R12", "pins after reset", pwm_out, 0);
      chk({ovf_flag, prd_flag, cmp_flag} == '0, "R12", "flags after reset",
          {ovf_flag, prd_flag, cmp_flag}, 0);
   endtask

   task automatic t_stopped_mode();
      logic [W-1:0] c0;
      cur_req = "R1";
      tick_en = 1'b1;
      wreg(3'd0, 16'd5);
      c0 = count;
      for (int k = 0; k < 20; k++) cyc();
      chk(count == c0 && !ovf_flag, "R1", "count frozen in code 5", count, c0);
   endtask

   task automatic t_mode1_mask();
      logic [W-1:0] prev;
      bit seen = 0, seen_ovf = 0;
      logic [W-1:0] at_flag = '0, at_ovf = '1;
      int mx = 0;
      cur_req = "R9";
      tick_en = 1'b1;
      wreg(3'd5, 16'h0000);
      wreg(3'd0, 16'd1);
      wreg(3'd2, 16'h1234);
      clear_all();
      prev = count;
      for (int k = 0; k < 600; k++) begin
         cyc();
         if (count > mx) mx = count;
         if (!seen && cmp_flag[0]) begin seen = 1; at_flag = prev; end
         if (!seen_ovf && ovf_flag) begin seen_ovf = 1; at_ovf = prev; end
         prev = count;
      end
      chk(seen && at_flag == 16'h0034, "R9", "count at masked match", at_flag, 16'h34);
      chk(mx == 16'h00FF, "R1", "peak count in code 1", mx, 16'hFF);
      chk(seen_ovf && at_ovf == 0, "R4", "count when bottom flag rose", at_ovf, 0);
   endtask

   task automatic t_tick_gate();
      logic [W-1:0] c0;
      cur_req = "R3";
      for (int k = 0; k < 90; k++) begin
         tick_en = (k % 3) != 0;
         cyc();
      end
      tick_en = 1'b0;
      c0 = count;
      for (int k = 0; k < 10; k++) cyc();
      chk(count == c0, "R3", "count with enable low", count, c0);
      tick_en = 1'b1;
   endtask

   task automatic t_mode10();
      logic [W-1:0] p1, p2;
      bit got = 0, turned = 0;
      cur_req = "R6";
      stop_and_home();
      tick_en = 1'b1;
      wreg(3'd1, 16'd40);
      wreg(3'd3, 16'd50);
      wreg(3'd5, 16'b10_10_10);
      wreg(3'd0, 16'd10);
      clear_all();
      p2 = count; p1 = count;
      for (int k = 0; k < 200; k++) begin
         cyc();
         if (!got && prd_flag) begin
            got = 1;
            chk(p1 == 16'd40, "R6", "count on period flag tick", p1, 40);
         end
         if (p2 == 16'd39 && p1 == 16'd40 && count == 16'd39) turned = 1;
         p2 = p1; p1 = count;
      end
      chk(got, "R6", "period flag seen", got, 1);
      chk(turned, "R2", "39-40-39 turn at TOP", turned, 1);
      chk(cmp_flag[1] == 1'b0, "R8", "channel B above TOP", cmp_flag[1], 0);
      chk(ovf_flag, "R4", "bottom flag in mode 10", ovf_flag, 1);
   endtask

   task automatic t_outputs();
      cur_req = "R10";
      wreg(3'd2, 16'd10);
      wreg(3'd4, 16'd20);
      wreg(3'd5, 16'b11_00_10);
      for (int k = 0; k < 170; k++) begin
         cyc();
         chk(pwm_out[1] == 1'b0, "R10", "pin B held low in mode 0", pwm_out[1], 0);
      end
      wreg(3'd5, 16'b10_01_11);
      for (int k = 0; k < 170; k++) cyc();
   endtask

   task automatic t_flags();
      cur_req = "R11";
      wait_count(16'd0);
      ovf_clr = 1'b1;
      cyc();
      chk(ovf_flag, "R11", "set beats clear", ovf_flag, 1);
      for (int k = 0; k < 5; k++) cyc();
      chk(ovf_flag, "R11", "flag sticky", ovf_flag, 1);
      ovf_clr = 1'b1; cmp_clr = '1;
      cyc();
      chk(!ovf_flag, "R11", "flag cleared", ovf_flag, 0);
   endtask

   task automatic wait_count(input logic [W-1:0] v);
      for (int k = 0; k < 400 && count != v; k++) cyc();
   endtask

   task automatic t_mode11();
      int mx1 = 0, mx2 = 0;
      bit flag_ok = 0;
      cur_req = "R5";
      stop_and_home();
      tick_en = 1'b1;
      wreg(3'd2, 16'd30);
      wreg(3'd3, 16'd12);
      wreg(3'd0, 16'd11);
      wait_count(16'd15);
      wreg(3'd2, 16'd50);
      for (int k = 0; k < 40; k++) begin
         cyc();
         if (count > mx1) mx1 = count;
      end
      chk(mx1 == 30, "R5", "old TOP kept until turn-around", mx1, 30);
      cmp_clr = 3'b001;
      cyc();
      for (int k = 0; k < 120; k++) begin
         cyc();
         if (count > mx2) mx2 = count;
         if (count == 16'd49 && cmp_flag[0]) flag_ok = 1;
      end
      chk(mx2 == 50, "R5", "new TOP after turn-around", mx2, 50);
      chk(flag_ok, "R6", "channel A flag at TOP in code 11", flag_ok, 1);
      chk(cmp_flag[1], "R7", "channel B match flag", cmp_flag[1], 1);
   endtask

   task automatic t_wide_modes();
      int mx = 0;
      cur_req = "R1";
      stop_and_home();
      tick_en = 1'b1;
      wreg(3'd0, 16'd2);
      wreg(3'd4, 16'hFFFF);
      wreg(3'd5, 16'b10_00_00);
      for (int k = 0; k < 1100; k++) begin
         cyc();
         if (count > mx) mx = count;
      end
      chk(mx == 16'h01FF, "R1", "peak count in code 2", mx, 16'h1FF);
      stop_and_home();
      tick_en = 1'b1;
      wreg(3'd0, 16'd3);
      mx = 0;
      for (int k = 0; k < 2100; k++) begin
         cyc();
         if (count > mx) mx = count;
      end
      chk(mx == 16'h03FF, "R1", "peak count in code 3", mx, 16'h3FF);
   endtask

   initial begin
      #(200000 * 20);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      model_on = 1'b1;
      t_stopped_mode();
      stop_and_home();
      t_mode1_mask();
      t_tick_gate();
      t_mode10();
      t_outputs();
      t_flags();
      t_mode11();
      t_wide_modes();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule